// File: doc/BRIEF.md
# Timer Bank Register Front End

This block sits between a simple 32-bit register bus and a bank of eight timer channels. It decodes word-aligned accesses into four registers per channel: a live count, a reload value and two match values. It also decodes a shared control word, which holds four bits per channel, and a second control word that is only stored. Reload and match values are held here and driven to the channels as levels. A write to a count register becomes a one-cycle load strobe that the channel's own counter consumes. Reads of a count register return the channel's live value.

When the control word is written, the block compares each channel's old and new bits and applies the changes in three phases, one cycle apart. First, channels that are being turned off are stopped. Next, the clock-select, overflow-interrupt and pulse bits are applied. Last, channels that are being turned on are started. Bits that do not change produce no strobe. The pulse mode bit is only honoured for channel indices 4 to 7. Illegal offsets, an unsupported pulse request, and a control write that arrives while a sequence is still running all raise a one-cycle error pulse.

Top module: `tmr_bank_regs`

## Requirements
- R1: After a synchronous reset, every enable, clock-select, interrupt and pulse output is 0, no strobe, response or error is active, and the control word reads back as 0.
- R2: Channel indices 0-2 occupy byte offsets 16*k to 16*k+15, and indices 3-7 occupy 16*(k+1) to 16*(k+1)+15. Within a channel, word 0 is count, word 1 is reload, word 2 is match A and word 3 is match B. A reload or match write appears on that channel's output in the cycle after the write and reads back unchanged.
- R3: A read of a count word returns that channel's count input as sampled with the request. A write to it raises only that channel's load strobe for exactly one cycle after the write, with the written value on the load data output.
- R4: The control word is at offset 0x30. Channel i uses bits 4i (enable), 4i+1 (external clock select), 4i+2 (overflow interrupt enable) and 4i+3 (pulse enable).
- R5: On an accepted control write, each channel whose enable goes from 1 to 0 has its enable output low and its stop strobe high in the cycle after the write. The strobe lasts one cycle.
- R6: One cycle after the stop phase, the clock-select, interrupt and pulse outputs take their new values. The config strobe pulses only for channels where one of those three bits changed.
- R7: One cycle after the config phase, each channel whose enable goes from 0 to 1 has its enable output high and its start strobe high for one cycle. Stop, config and start strobes never coincide.
- R8: A control write that changes no bit of a channel produces no strobe for that channel, and its enable output does not move.
- R9: Pulse bits (3, 7, 11, 15) of channels 0-3 are dropped. They read back as 0, their pulse outputs stay 0, and setting any of them raises the error pulse. Pulse bits of channels 4-7 are honoured.
- R10: Offsets 0x38, 0x3C, 0x90 and above, and any address with bits [1:0] not zero are illegal. Reads of them return 0, writes to them change nothing, and each raises the error output for one cycle after the request.
- R11: Offset 0x34 holds a 32-bit word that reads back as written and affects no channel output.
- R12: A control write sampled in either of the two cycles after an accepted control write is discarded and raises the error pulse. The control word keeps the earlier value.
- R13: A read returns its data with the response valid bit in the cycle after the request. Writes raise no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| err_o | output | 1 | One-cycle access error pulse |
| ch_count_i | input | 8*32 | Live count of each channel |
| count_ld_o | output | 8 | Per-channel count load strobe |
| count_ld_data_o | output | 32 | Count load value |
| reload_o | output | 8*32 | Reload value per channel |
| match_a_o | output | 8*32 | Match A value per channel |
| match_b_o | output | 8*32 | Match B value per channel |
| en_o | output | 8 | Channel running |
| ext_clk_o | output | 8 | External clock select |
| ovf_irq_o | output | 8 | Overflow interrupt enable |
| pulse_o | output | 8 | Pulse mode enable |
| stop_stb_o | output | 8 | Stop strobe |
| cfg_stb_o | output | 8 | Configuration change strobe |
| start_stb_o | output | 8 | Start strobe |

## Verification
Read data, error pulses, load strobes and reload/match levels are all due in the cycle after the request is sampled. A control write's stop phase is due one cycle after, the config phase two cycles after and the start phase three cycles after. The bench drives requests on the falling edge and keeps a behavioural model that advances on each rising edge. It compares every output on the following falling edge, so each check samples exactly the cycle the model gives for that result. Directed checks then wait the phase-specific number of falling edges before comparing against constants.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

    localparam int DATA_W      = 32;
    localparam int CH_N        = 8;
    localparam int CH_W        = $clog2(CH_N);
    localparam int CTRL_BITS   = 4;
    localparam int PULSE_BIT   = 3;
    localparam int PULSE_FIRST = 4;
    localparam int OFF_W       = 8;

    localparam logic [OFF_W-1:0] CTRL_OFF   = 8'h30;
    localparam logic [OFF_W-1:0] CTRL2_OFF  = 8'h34;
    localparam logic [OFF_W-1:0] LOW_END    = 8'h30;
    localparam logic [OFF_W-1:0] HIGH_BASE  = 8'h40;
    localparam logic [OFF_W-1:0] HIGH_LAST  = 8'h8F;

    typedef enum logic [1:0] {AK_ILLEGAL, AK_CHAN, AK_CTRL, AK_CTRL2} acc_kind_e;
    typedef enum logic [1:0] {CR_COUNT, CR_RELOAD, CR_MATCH_A, CR_MATCH_B} chan_reg_e;
    typedef enum logic [1:0] {SEQ_IDLE, SEQ_CFG, SEQ_START} seq_phase_e;

    typedef struct packed {
        acc_kind_e        kind;
        logic [CH_W-1:0]  ch;
        chan_reg_e        sel;
    } acc_dec_t;

    typedef struct packed {
        logic pulse;
        logic ovf_irq;
        logic ext_clk;
        logic en;
    } chan_ctrl_t;

    typedef chan_ctrl_t [CH_N-1:0] ctrl_word_t;

    function automatic logic [DATA_W-1:0] mask_pulse(input logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] m;
        m = w;
        for (int i = 0; i < PULSE_FIRST; i++) m[i*CTRL_BITS+PULSE_BIT] = 1'b0;
        return m;
    endfunction

    function automatic logic pulse_violation(input logic [DATA_W-1:0] w);
        logic v;
        v = 1'b0;
        for (int i = 0; i < PULSE_FIRST; i++) v = v | w[i*CTRL_BITS+PULSE_BIT];
        return v;
    endfunction

endpackage

// File: rtl/tmr_addr_decode.sv
module tmr_addr_decode
    import tmr_bank_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_dec_t          dec
);
    logic             hi_ok;
    logic [OFF_W-1:0] off;
    logic [3:0]       slot;

    assign off  = addr[OFF_W-1:0];
    assign slot = off[7:4];

    if (ADDR_W > OFF_W) begin : g_hi
        assign hi_ok = ~|addr[ADDR_W-1:OFF_W];
    end else begin : g_nohi
        assign hi_ok = 1'b1;
    end

    always_comb begin
        dec.kind = AK_ILLEGAL;
        dec.ch   = '0;
        dec.sel  = chan_reg_e'(off[3:2]);
        if (hi_ok && off[1:0] == 2'b00) begin
            if (off < LOW_END) begin
                dec.kind = AK_CHAN;
                dec.ch   = CH_W'(slot);
            end else if (off == CTRL_OFF) begin
                dec.kind = AK_CTRL;
            end else if (off == CTRL2_OFF) begin
                dec.kind = AK_CTRL2;
            end else if (off >= HIGH_BASE && off <= HIGH_LAST) begin
                dec.kind = AK_CHAN;
                dec.ch   = CH_W'(slot - 4'd1);
            end
        end
    end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_bank_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [CH_W-1:0]          ch,
    input  chan_reg_e                sel,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [CH_N*DATA_W-1:0]   count_i,
    output logic [DATA_W-1:0]        rd_data,
    output logic [CH_N-1:0]          ld_o,
    output logic [DATA_W-1:0]        ld_data_o,
    output logic [CH_N*DATA_W-1:0]   reload_o,
    output logic [CH_N*DATA_W-1:0]   ma_o,
    output logic [CH_N*DATA_W-1:0]   mb_o
);
    logic [DATA_W-1:0] rel_q [CH_N];
    logic [DATA_W-1:0] ma_q  [CH_N];
    logic [DATA_W-1:0] mb_q  [CH_N];

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                rel_q[g] <= '0;
                ma_q[g]  <= '0;
                mb_q[g]  <= '0;
            end else if (wr_en && ch == CH_W'(g)) begin
                case (sel)
                    CR_RELOAD:  rel_q[g] <= wdata;
                    CR_MATCH_A: ma_q[g]  <= wdata;
                    CR_MATCH_B: mb_q[g]  <= wdata;
                    default: ;
                endcase
            end
        end
        assign reload_o[g*DATA_W +: DATA_W] = rel_q[g];
        assign ma_o[g*DATA_W +: DATA_W]     = ma_q[g];
        assign mb_o[g*DATA_W +: DATA_W]     = mb_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_o      <= '0;
            ld_data_o <= '0;
        end else begin
            ld_o <= '0;
            if (wr_en && sel == CR_COUNT) begin
                ld_o[ch]  <= 1'b1;
                ld_data_o <= wdata;
            end
        end
    end

    always_comb begin
        case (sel)
            CR_COUNT:   rd_data = count_i[int'(ch)*DATA_W +: DATA_W];
            CR_RELOAD:  rd_data = rel_q[ch];
            CR_MATCH_A: rd_data = ma_q[ch];
            default:    rd_data = mb_q[ch];
        endcase
    end
endmodule

// File: rtl/tmr_ctrl_seq.sv
module tmr_ctrl_seq
    import tmr_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [DATA_W-1:0] wword,
    output logic              busy,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [CH_N-1:0]   en_o,
    output logic [CH_N-1:0]   ext_o,
    output logic [CH_N-1:0]   ovf_o,
    output logic [CH_N-1:0]   pulse_o,
    output logic [CH_N-1:0]   stop_o,
    output logic [CH_N-1:0]   cfg_o,
    output logic [CH_N-1:0]   start_o
);
    ctrl_word_t  cur_q, old_q, new_q, masked;
    seq_phase_e  ph_q;

    assign masked    = ctrl_word_t'(mask_pulse(wword));
    assign busy      = (ph_q != SEQ_IDLE);
    assign ctrl_word = DATA_W'(cur_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            old_q   <= '0;
            new_q   <= '0;
            ph_q    <= SEQ_IDLE;
            en_o    <= '0;
            ext_o   <= '0;
            ovf_o   <= '0;
            pulse_o <= '0;
            stop_o  <= '0;
            cfg_o   <= '0;
            start_o <= '0;
        end else begin
            stop_o  <= '0;
            cfg_o   <= '0;
            start_o <= '0;
            case (ph_q)
                SEQ_IDLE: begin
                    if (go) begin
                        cur_q <= masked;
                        old_q <= cur_q;
                        new_q <= masked;
                        ph_q  <= SEQ_CFG;
                        for (int i = 0; i < CH_N; i++) begin
                            if (cur_q[i].en && !masked[i].en) begin
                                en_o[i]   <= 1'b0;
                                stop_o[i] <= 1'b1;
                            end
                        end
                    end
                end
                SEQ_CFG: begin
                    for (int i = 0; i < CH_N; i++) begin
                        ext_o[i]   <= new_q[i].ext_clk;
                        ovf_o[i]   <= new_q[i].ovf_irq;
                        pulse_o[i] <= new_q[i].pulse;
                        cfg_o[i]   <= (new_q[i].ext_clk != old_q[i].ext_clk) ||
                                      (new_q[i].ovf_irq != old_q[i].ovf_irq) ||
                                      (new_q[i].pulse   != old_q[i].pulse);
                    end
                    ph_q <= SEQ_START;
                end
                SEQ_START: begin
                    for (int i = 0; i < CH_N; i++) begin
                        if (!old_q[i].en && new_q[i].en) begin
                            en_o[i]    <= 1'b1;
                            start_o[i] <= 1'b1;
                        end
                    end
                    ph_q <= SEQ_IDLE;
                end
                default: ph_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tmr_bank_regs.sv
module tmr_bank_regs
    import tmr_bank_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   err_o,
    input  logic [CH_N*DATA_W-1:0] ch_count_i,
    output logic [CH_N-1:0]        count_ld_o,
    output logic [DATA_W-1:0]      count_ld_data_o,
    output logic [CH_N*DATA_W-1:0] reload_o,
    output logic [CH_N*DATA_W-1:0] match_a_o,
    output logic [CH_N*DATA_W-1:0] match_b_o,
    output logic [CH_N-1:0]        en_o,
    output logic [CH_N-1:0]        ext_clk_o,
    output logic [CH_N-1:0]        ovf_irq_o,
    output logic [CH_N-1:0]        pulse_o,
    output logic [CH_N-1:0]        stop_stb_o,
    output logic [CH_N-1:0]        cfg_stb_o,
    output logic [CH_N-1:0]        start_stb_o
);
    acc_dec_t          dec;
    logic [DATA_W-1:0] chan_rd, ctrl_rd, ctrl2_q, rd_mux;
    logic              rd_req, wr_req, ctrl_wr, seq_busy, seq_go, err_d;

    tmr_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    assign rd_req  = req_valid && !req_write;
    assign wr_req  = req_valid && req_write;
    assign ctrl_wr = wr_req && dec.kind == AK_CTRL;
    assign seq_go  = ctrl_wr && !seq_busy;

    tmr_chan_regs u_chan (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_req && dec.kind == AK_CHAN),
        .ch        (dec.ch),
        .sel       (dec.sel),
        .wdata     (req_wdata),
        .count_i   (ch_count_i),
        .rd_data   (chan_rd),
        .ld_o      (count_ld_o),
        .ld_data_o (count_ld_data_o),
        .reload_o  (reload_o),
        .ma_o      (match_a_o),
        .mb_o      (match_b_o)
    );

    tmr_ctrl_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (seq_go),
        .wword     (req_wdata),
        .busy      (seq_busy),
        .ctrl_word (ctrl_rd),
        .en_o      (en_o),
        .ext_o     (ext_clk_o),
        .ovf_o     (ovf_irq_o),
        .pulse_o   (pulse_o),
        .stop_o    (stop_stb_o),
        .cfg_o     (cfg_stb_o),
        .start_o   (start_stb_o)
    );

    always_comb begin
        case (dec.kind)
            AK_CHAN:  rd_mux = chan_rd;
            AK_CTRL:  rd_mux = ctrl_rd;
            AK_CTRL2: rd_mux = ctrl2_q;
            default:  rd_mux = '0;
        endcase
    end

    assign err_d = req_valid && ((dec.kind == AK_ILLEGAL) ||
                   (ctrl_wr && (seq_busy || pulse_violation(req_wdata))));

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            err_o     <= 1'b0;
            ctrl2_q   <= '0;
        end else begin
            rsp_valid <= rd_req;
            rsp_rdata <= rd_req ? rd_mux : '0;
            err_o     <= err_d;
            if (wr_req && dec.kind == AK_CTRL2) ctrl2_q <= req_wdata;
        end
    end
endmodule

// File: rtl/tmr_bank_regs_chk.sv
module tmr_bank_regs_chk
    import tmr_bank_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_write,
    input logic            rsp_valid,
    input logic            err_o,
    input logic [CH_N-1:0] count_ld_o,
    input logic [CH_N-1:0] en_o,
    input logic [CH_N-1:0] stop_stb_o,
    input logic [CH_N-1:0] cfg_stb_o,
    input logic [CH_N-1:0] start_stb_o
);
    // R5: a stop only hits running channels and leaves them off
    assert_stop_from_running_R5: assert property (@(posedge clk) disable iff (rst)
        (|stop_stb_o) |-> ((($past(en_o) & stop_stb_o) == stop_stb_o) && ((en_o & stop_stb_o) == '0)));

    // R7: a start only hits idle channels and leaves them running
    assert_start_from_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (|start_stb_o) |-> ((($past(en_o) & start_stb_o) == '0) && ((en_o & start_stb_o) == start_stb_o)));

    // R7: the three phases never share a cycle
    assert_phases_apart_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({|stop_stb_o, |cfg_stb_o, |start_stb_o}));

    // R8: enables move only alongside a stop or start strobe
    assert_en_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (stop_stb_o == '0 && start_stb_o == '0) |-> $stable(en_o));

    // R3: at most one channel loads at a time
    assert_single_load_R3: assert property (@(posedge clk) disable iff (rst)
        (|count_ld_o) |-> ($countones(count_ld_o) == 1));

    // R13: a response follows a read request
    assert_rsp_after_read_R13: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));

    // R10: an error follows some request
    assert_err_after_req_R10: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(req_valid));
endmodule

bind tmr_bank_regs tmr_bank_regs_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .rsp_valid   (rsp_valid),
    .err_o       (err_o),
    .count_ld_o  (count_ld_o),
    .en_o        (en_o),
    .stop_stb_o  (stop_stb_o),
    .cfg_stb_o   (cfg_stb_o),
    .start_stb_o (start_stb_o)
);

// File: tb/tmr_bank_regs_tb.sv
`timescale 1ns/1ps
module tmr_bank_regs_tb_top;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid, err_o;
    logic [31:0]   rsp_rdata, count_ld_data_o;
    logic [255:0]  ch_count;
    logic [7:0]    count_ld_o, en_o, ext_clk_o, ovf_irq_o, pulse_o, stop_stb_o, cfg_stb_o, start_stb_o;
    logic [255:0]  reload_o, match_a_o, match_b_o;

    int n_chk = 0, n_fail = 0;
    logic running = 1'b0;

    always #2 clk = ~clk;

    tmr_bank_regs #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .err_o(err_o), .ch_count_i(ch_count),
        .count_ld_o(count_ld_o), .count_ld_data_o(count_ld_data_o),
        .reload_o(reload_o), .match_a_o(match_a_o), .match_b_o(match_b_o),
        .en_o(en_o), .ext_clk_o(ext_clk_o), .ovf_irq_o(ovf_irq_o), .pulse_o(pulse_o),
        .stop_stb_o(stop_stb_o), .cfg_stb_o(cfg_stb_o), .start_stb_o(start_stb_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    localparam logic [31:0] LOW_PULSE = 32'h0000_8888;
    logic [31:0] m_ctrl, m_ctrl2, m_pold, m_pnew, m_rdata, m_lddata;
    logic [31:0] m_rel [8], m_ma [8], m_mb [8];
    logic [7:0]  m_en, m_ext, m_ovf, m_pul, m_stop, m_cfgs, m_start, m_ld;
    logic        m_rvalid, m_err;
    int          m_phase;

    always @(posedge clk) begin : model
        int ph0, off, ch, r, kind;
        logic [31:0] w;
        m_rvalid = 0; m_rdata = 0; m_err = 0;
        m_stop = 0; m_cfgs = 0; m_start = 0; m_ld = 0;
        if (rst) begin
            m_ctrl = 0; m_ctrl2 = 0; m_pold = 0; m_pnew = 0; m_lddata = 0;
            m_en = 0; m_ext = 0; m_ovf = 0; m_pul = 0; m_phase = 0;
            for (int i = 0; i < 8; i++) begin m_rel[i] = 0; m_ma[i] = 0; m_mb[i] = 0; end
        end else begin
            ph0 = m_phase;
            if (ph0 == 1) begin
                for (int i = 0; i < 8; i++) begin
                    if (m_pnew[4*i+1 +: 3] != m_pold[4*i+1 +: 3]) m_cfgs[i] = 1;
                    m_ext[i] = m_pnew[4*i+1];
                    m_ovf[i] = m_pnew[4*i+2];
                    m_pul[i] = m_pnew[4*i+3];
                end
                m_phase = 2;
            end else if (ph0 == 2) begin
                for (int i = 0; i < 8; i++)
                    if (!m_pold[4*i] && m_pnew[4*i]) begin m_en[i] = 1; m_start[i] = 1; end
                m_phase = 0;
            end
            if (req_valid) begin
                off = int'(req_addr); kind = 0; ch = 0;
                if (off % 4 == 0 && off < 256) begin
                    if (off < 48) begin kind = 1; ch = off / 16; end
                    else if (off == 48) kind = 2;
                    else if (off == 52) kind = 3;
                    else if (off >= 64 && off < 144) begin kind = 1; ch = off / 16 - 1; end
                end
                r = (off % 16) / 4;
                if (kind == 0) m_err = 1;
                if (!req_write) begin
                    m_rvalid = 1;
                    if (kind == 1) begin
                        case (r)
                            0: m_rdata = ch_count[ch*32 +: 32];
                            1: m_rdata = m_rel[ch];
                            2: m_rdata = m_ma[ch];
                            default: m_rdata = m_mb[ch];
                        endcase
                    end else if (kind == 2) m_rdata = m_ctrl;
                    else if (kind == 3) m_rdata = m_ctrl2;
                end else begin
                    if (kind == 1) begin
                        case (r)
                            0: begin m_ld[ch] = 1; m_lddata = req_wdata; end
                            1: m_rel[ch] = req_wdata;
                            2: m_ma[ch] = req_wdata;
                            default: m_mb[ch] = req_wdata;
                        endcase
                    end else if (kind == 3) m_ctrl2 = req_wdata;
                    else if (kind == 2) begin
                        if ((req_wdata & LOW_PULSE) != 0) m_err = 1;
                        if (ph0 != 0) m_err = 1;
                        else begin
                            w = req_wdata & ~LOW_PULSE;
                            m_pold = m_ctrl; m_pnew = w; m_ctrl = w;
                            for (int i = 0; i < 8; i++)
                                if (m_pold[4*i] && !w[4*i]) begin m_en[i] = 0; m_stop[i] = 1; end
                            m_phase = 1;
                        end
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && running) begin
            chk("R13 rsp_valid", 32'(rsp_valid), 32'(m_rvalid));
            chk("R13 rsp_rdata", rsp_rdata, m_rdata);
            chk("R10 err_o", 32'(err_o), 32'(m_err));
            chk("R5 en_o", 32'(en_o), 32'(m_en));
            chk("R6 ext_clk_o", 32'(ext_clk_o), 32'(m_ext));
            chk("R6 ovf_irq_o", 32'(ovf_irq_o), 32'(m_ovf));
            chk("R9 pulse_o", 32'(pulse_o), 32'(m_pul));
            chk("R5 stop_stb_o", 32'(stop_stb_o), 32'(m_stop));
            chk("R8 cfg_stb_o", 32'(cfg_stb_o), 32'(m_cfgs));
            chk("R7 start_stb_o", 32'(start_stb_o), 32'(m_start));
            chk("R3 count_ld_o", 32'(count_ld_o), 32'(m_ld));
            if (m_ld != 0) chk("R3 count_ld_data_o", count_ld_data_o, m_lddata);
            for (int i = 0; i < 8; i++) begin
                chk("R2 reload_o", reload_o[i*32 +: 32], m_rel[i]);
                chk("R2 match_a_o", match_a_o[i*32 +: 32], m_ma[i]);
                chk("R2 match_b_o", match_b_o[i*32 +: 32], m_mb[i]);
            end
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        chk({tag, " read data"}, rsp_rdata, exp);
        chk("R13 read valid", 32'(rsp_valid), 32'd1);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] seen;
        for (int i = 0; i < 8; i++) ch_count[i*32 +: 32] = 32'hC0DE_0000 + 32'(i);
        repeat (3) @(negedge clk);
        rst = 0;
        running = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 en_o", 32'(en_o), 0);
        chk("R1 ext/ovf/pulse", 32'(ext_clk_o | ovf_irq_o | pulse_o), 0);
        chk("R1 strobes", 32'(stop_stb_o | cfg_stb_o | start_stb_o | count_ld_o), 0);
        chk("R1 err/rsp", 32'({err_o, rsp_valid}), 0);
        bus_rd(12'h030, 32'h0, "R1 ctrl");

        // R2 channel map
        bus_wr(12'h004, 32'h1111_0004);
        chk("R2 reload ch0", reload_o[31:0], 32'h1111_0004);
        bus_wr(12'h048, 32'hA5A5_0003);
        chk("R2 match_a ch3", match_a_o[3*32 +: 32], 32'hA5A5_0003);
        bus_wr(12'h08C, 32'h0000_BEEF);
        chk("R2 match_b ch7", match_b_o[7*32 +: 32], 32'h0000_BEEF);
        bus_wr(12'h028, 32'h0000_0022);
        bus_rd(12'h004, 32'h1111_0004, "R2 ch0 reload");
        bus_rd(12'h048, 32'hA5A5_0003, "R2 ch3 match_a");
        bus_rd(12'h08C, 32'h0000_BEEF, "R2 ch7 match_b");
        bus_rd(12'h028, 32'h0000_0022, "R2 ch2 match_a");

        // R3 count path
        bus_rd(12'h060, 32'hC0DE_0005, "R3 ch5 count");
        bus_rd(12'h010, 32'hC0DE_0001, "R3 ch1 count");
        bus_wr(12'h050, 32'h0000_0077);
        chk("R3 load strobe", 32'(count_ld_o), 32'h10);
        chk("R3 load data", count_ld_data_o, 32'h77);
        @(negedge clk);
        chk("R3 load one cycle", 32'(count_ld_o), 0);

        // R4 / R6 / R7: enable ch2 with ext clock and interrupt
        bus_wr(12'h030, 32'h0000_0700);
        chk("R7 not yet enabled", 32'(en_o), 0);
        @(negedge clk);
        chk("R4 ext bit", 32'(ext_clk_o), 32'h04);
        chk("R4 ovf bit", 32'(ovf_irq_o), 32'h04);
        chk("R6 cfg strobe", 32'(cfg_stb_o), 32'h04);
        @(negedge clk);
        chk("R4 enable bit", 32'(en_o), 32'h04);
        chk("R7 start strobe", 32'(start_stb_o), 32'h04);
        bus_rd(12'h030, 32'h0000_0700, "R4 ctrl");

        // R5 disable ch2, config unchanged
        bus_wr(12'h030, 32'h0000_0600);
        chk("R5 en low", 32'(en_o), 0);
        chk("R5 stop strobe", 32'(stop_stb_o), 32'h04);
        @(negedge clk);
        chk("R5 stop one cycle", 32'(stop_stb_o), 0);
        chk("R8 no cfg strobe", 32'(cfg_stb_o), 0);
        @(negedge clk);
        chk("R8 no start strobe", 32'(start_stb_o), 0);

        // R9 pulse on a lower channel
        bus_wr(12'h030, 32'h0000_8000);
        chk("R9 lower pulse error", 32'(err_o), 1);
        settle();
        chk("R9 lower pulse output", 32'(pulse_o), 0);
        bus_rd(12'h030, 32'h0, "R9 ctrl masked");
        bus_wr(12'h030, 32'h8000_0000);
        chk("R9 upper pulse no error", 32'(err_o), 0);
        @(negedge clk);
        chk("R9 upper pulse output", 32'(pulse_o), 32'h80);
        @(negedge clk);
        bus_rd(12'h030, 32'h8000_0000, "R9 ctrl upper");

        // R8 rewrite identical word
        bus_wr(12'h030, 32'h8000_0000);
        seen = stop_stb_o | cfg_stb_o | start_stb_o;
        @(negedge clk); seen |= stop_stb_o | cfg_stb_o | start_stb_o;
        @(negedge clk); seen |= stop_stb_o | cfg_stb_o | start_stb_o;
        chk("R8 no strobes on rewrite", 32'(seen), 0);
        chk("R8 pulse held", 32'(pulse_o), 32'h80);

        // R12 back-to-back control writes
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 12'h030; req_wdata = 32'h0000_0001;
        @(negedge clk);
        req_wdata = 32'h0000_0010;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        chk("R12 busy error", 32'(err_o), 1);
        settle();
        chk("R12 first write applied", 32'(en_o), 32'h01);
        bus_rd(12'h030, 32'h0000_0001, "R12 ctrl kept");

        // R10 illegal offsets
        bus_rd(12'h038, 32'h0, "R10 0x38");
        chk("R10 err 0x38", 32'(err_o), 1);
        bus_wr(12'h03C, 32'hFFFF_FFFF);
        chk("R10 err 0x3C", 32'(err_o), 1);
        bus_wr(12'h090, 32'hFFFF_FFFF);
        chk("R10 err 0x90", 32'(err_o), 1);
        bus_wr(12'h006, 32'h1234_5678);
        chk("R10 err misaligned", 32'(err_o), 1);
        bus_rd(12'h031, 32'h0, "R10 misaligned read");
        chk("R10 err misaligned read", 32'(err_o), 1);
        bus_rd(12'h204, 32'h0, "R10 high address");
        bus_rd(12'h004, 32'h1111_0004, "R10 reload untouched");
        bus_rd(12'h030, 32'h0000_0001, "R10 ctrl untouched");

        // R11 second control word
        bus_wr(12'h034, 32'hDEAD_BEEF);
        chk("R11 no error", 32'(err_o), 0);
        chk("R11 no strobe", 32'(stop_stb_o | cfg_stb_o | start_stb_o), 0);
        bus_rd(12'h034, 32'hDEAD_BEEF, "R11 ctrl2");
        chk("R11 en unchanged", 32'(en_o), 32'h01);

        // R13 writes raise no response
        bus_wr(12'h014, 32'h5);
        chk("R13 no response on write", 32'(rsp_valid), 0);

        repeat (2) @(negedge clk);
        running = 0;
        summary();
        $finish;
    end
endmodule